// File: doc/BRIEF.md
# Multi-Issue Dependency Matrix

This block is the hazard tracker at the issue stage of a scoreboard-style out-of-order core. It holds a small pool of in-flight instruction entries. For each entry it keeps a row of wait bits, one bit for every other entry. Each cycle it can take in a batch of up to four decoded instructions. Every instruction names one destination register and up to two source registers.

For each new instruction the block compares its registers with those of the live entries and sets wait bits for three kinds of hazard:
- A read that follows a pending write.
- A write that would overtake a pending read.
- A write that follows a pending write.

Inside a batch, an instruction also takes a wait bit for any earlier slot it conflicts with. It then ORs in the complete wait rows of all earlier slots in the batch. Because ordering hazards are transitive, the whole batch can be written into the matrix in one cycle, and no batch is refused because its registers overlap.

A completion pulse for an entry clears that entry's column in every row and frees the entry. The block reports which entries are occupied, which are ready (occupied with no outstanding wait), and which entry each accepted slot was given.

Top module: `issue_dep_matrix`

## Requirements
- R1: After a synchronous active-low reset, no entry is busy or ready. When no slot is valid, `batch_accept` is low and `slot_entry` is all zero.
- R2: Valid slots are given free entries in ascending entry index, in slot order, and skip invalid slots. `slot_entry` holds the entry index of slot k in bits [3k+2:3k], and is 0 for invalid slots and whenever the batch is not accepted.
- R3: A batch is accepted only when at least one slot is valid and the free entries cover every valid slot. Otherwise no entry is allocated, and only completions change the state.
- R4: A new instruction waits on a live entry whose destination equals either of its sources (read after write).
- R5: A new instruction waits on a live entry that reads the register it writes (write after read).
- R6: A new instruction waits on a live entry that writes the same destination (write after write).
- R7: Register 0 never creates a wait, whether it is used as a source or as a destination.
- R8: A slot waits on each earlier valid slot of its batch that it conflicts with. It also inherits every wait bit of all earlier valid slots in the same batch, even when it has no conflict of its own.
- R9: A completion pulse on a busy entry clears its column in every row, and the entry is free from the next cycle (not in the same cycle). Instructions entering in that same cycle do not wait on it. A completion pulse on a free entry has no effect.
- R10: An entry is ready exactly when it is busy and its wait row is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 4 | Per-slot valid, slot 0 is oldest |
| in_dst | input | 20 | Destination register per slot, 5 bits each, 0 = none |
| in_src_a | input | 20 | First source register per slot, 0 = none |
| in_src_b | input | 20 | Second source register per slot, 0 = none |
| done_pulse | input | 8 | Per-entry completion pulse |
| batch_accept | output | 1 | The presented batch is written this cycle |
| slot_entry | output | 12 | Entry index given to each slot, 3 bits each |
| entry_busy | output | 8 | Entry holds an in-flight instruction |
| entry_ready | output | 8 | Entry is busy and waits on nothing |

## Verification
The hardest situation to reach is an instruction that has no register conflict of its own but still must not become ready, because it inherited the waits of an earlier slot in its batch. The stimulus first fills half the pool with a chain of read, anti and output hazards. It then issues a four-wide batch in which only slot 0 conflicts with those entries, and checks that the unrelated later slots stay blocked until the older entries complete. A second hard case places a completion and a dependent allocation in the same cycle. The bench checks that the new entry does not wait on the entry that is retiring.

// File: rtl/idm_pkg.sv
// Package: shared default sizing for the multi-issue dependency matrix.
// Assumes: consumers derive all widths from these defaults.
package idm_pkg;
    localparam int unsigned IDM_ENTRIES = 8;   // in-flight entries in the matrix
    localparam int unsigned IDM_ISSUE   = 4;   // slots per issue batch
    localparam int unsigned IDM_REGS    = 32;  // architectural registers
endpackage

// File: rtl/idm_hazard_vec.sv
// Module: compares one new instruction against a set of candidate instructions
// and flags every candidate it must wait on (read-after-write, write-after-read,
// write-after-write). Register 0 never matches.
// Assumes: cand_en already excludes candidates that must not be considered.
module idm_hazard_vec #(
    parameter int unsigned CANDS = 8,
    parameter int unsigned RW    = 5
) (
    input  logic [RW-1:0]       new_dst,
    input  logic [RW-1:0]       new_src_a,
    input  logic [RW-1:0]       new_src_b,
    input  logic [CANDS-1:0]    cand_en,
    input  logic [CANDS*RW-1:0] cand_dst,
    input  logic [CANDS*RW-1:0] cand_src_a,
    input  logic [CANDS*RW-1:0] cand_src_b,
    output logic [CANDS-1:0]    hit
);
    logic new_writes;
    assign new_writes = (new_dst != '0);

    for (genvar j = 0; j < CANDS; j++) begin : g_cand
        logic [RW-1:0] c_dst, c_sa, c_sb;
        logic raw, war, waw;
        assign c_dst = cand_dst[j*RW +: RW];
        assign c_sa  = cand_src_a[j*RW +: RW];
        assign c_sb  = cand_src_b[j*RW +: RW];
        // reader after pending writer
        assign raw = (c_dst != '0) && ((new_src_a == c_dst) || (new_src_b == c_dst));
        // writer after pending reader
        assign war = new_writes && ((new_dst == c_sa) || (new_dst == c_sb));
        // writer after pending writer
        assign waw = new_writes && (new_dst == c_dst);
        assign hit[j] = cand_en[j] && (raw || war || waw);
    end
endmodule

// File: rtl/idm_alloc.sv
// Module: hands out free entries to the valid slots of a batch, lowest free
// index first, in slot order. Reports whether every valid slot got one.
// Assumes: the caller ignores the grants unless 'enough' is set.
module idm_alloc #(
    parameter int unsigned N  = 8,
    parameter int unsigned W  = 4,
    parameter int unsigned IW = 3
) (
    input  logic [N-1:0]    free_vec,
    input  logic [W-1:0]    req,
    output logic [W*N-1:0]  grant_oh,
    output logic [W*IW-1:0] grant_idx,
    output logic            enough
);
    // walk the slots, peeling the lowest free bit off for each valid slot
    always_comb begin
        logic [N-1:0] avail;
        logic [N-1:0] pick;
        avail     = free_vec;
        enough    = 1'b1;
        grant_oh  = '0;
        grant_idx = '0;
        for (int k = 0; k < W; k++) begin
            pick = avail & (~avail + 1'b1);
            if (req[k]) begin
                if (pick == '0) enough = 1'b0;
                grant_oh[k*N +: N] = pick;
                avail = avail & ~pick;
                for (int j = 0; j < N; j++) begin
                    if (pick[j]) grant_idx[k*IW +: IW] = IW'(j);
                end
            end
        end
    end
endmodule

// File: rtl/issue_dep_matrix.sv
// Module: issue-stage dependency matrix. Keeps per-entry register fields and a
// wait row per entry, admits whole batches, chains in-batch dependencies
// transitively and clears columns on completion.
// Assumes: slot 0 is the oldest instruction in a batch; register 0 means "none".
module issue_dep_matrix #(
    parameter int unsigned NUM_ENTRIES = idm_pkg::IDM_ENTRIES,
    parameter int unsigned ISSUE_WIDTH = idm_pkg::IDM_ISSUE,
    parameter int unsigned NUM_REGS    = idm_pkg::IDM_REGS
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [ISSUE_WIDTH-1:0]                  in_valid,
    input  logic [ISSUE_WIDTH*$clog2(NUM_REGS)-1:0] in_dst,
    input  logic [ISSUE_WIDTH*$clog2(NUM_REGS)-1:0] in_src_a,
    input  logic [ISSUE_WIDTH*$clog2(NUM_REGS)-1:0] in_src_b,
    input  logic [NUM_ENTRIES-1:0]                  done_pulse,
    output logic                                    batch_accept,
    output logic [ISSUE_WIDTH*$clog2(NUM_ENTRIES)-1:0] slot_entry,
    output logic [NUM_ENTRIES-1:0]                  entry_busy,
    output logic [NUM_ENTRIES-1:0]                  entry_ready
);
    localparam int unsigned N  = NUM_ENTRIES;
    localparam int unsigned W  = ISSUE_WIDTH;
    localparam int unsigned RW = $clog2(NUM_REGS);
    localparam int unsigned IW = $clog2(NUM_ENTRIES);
    localparam int unsigned SW = (W > 1) ? $clog2(W) : 1;

    logic [N-1:0]    busy_q;
    logic [N*RW-1:0] dst_q, sa_q, sb_q;
    logic [N-1:0]    dep_q [N];

    logic [N-1:0]    live;
    logic [W*N-1:0]  grant_oh;
    logic [W*IW-1:0] grant_idx;
    logic            enough;
    logic            accept;
    logic [N-1:0]    mat_hit [W];
    logic [W-1:0]    bat_hit [W];
    logic [N-1:0]    new_row [W];
    logic [N-1:0]    we;
    logic [SW-1:0]   ws [N];
    logic [N-1:0]    col_any;

    // entries that still count as producers/consumers this cycle
    assign live = busy_q & ~done_pulse;

    idm_alloc #(.N(N), .W(W), .IW(IW)) u_alloc (
        .free_vec  (~busy_q),
        .req       (in_valid),
        .grant_oh  (grant_oh),
        .grant_idx (grant_idx),
        .enough    (enough)
    );

    assign accept       = (|in_valid) && enough;
    assign batch_accept = accept;
    assign slot_entry   = accept ? grant_idx : '0;

    for (genvar k = 0; k < W; k++) begin : g_slot
        localparam logic [W-1:0] OLDER = W'((1 << k) - 1);
        // hazards against the stored matrix
        idm_hazard_vec #(.CANDS(N), .RW(RW)) u_mat (
            .new_dst    (in_dst[k*RW +: RW]),
            .new_src_a  (in_src_a[k*RW +: RW]),
            .new_src_b  (in_src_b[k*RW +: RW]),
            .cand_en    (live),
            .cand_dst   (dst_q),
            .cand_src_a (sa_q),
            .cand_src_b (sb_q),
            .hit        (mat_hit[k])
        );
        // hazards against older slots of the same batch
        idm_hazard_vec #(.CANDS(W), .RW(RW)) u_bat (
            .new_dst    (in_dst[k*RW +: RW]),
            .new_src_a  (in_src_a[k*RW +: RW]),
            .new_src_b  (in_src_b[k*RW +: RW]),
            .cand_en    (in_valid & OLDER),
            .cand_dst   (in_dst),
            .cand_src_a (in_src_a),
            .cand_src_b (in_src_b),
            .hit        (bat_hit[k])
        );
    end

    // build each slot's row: own hazards, older-slot entries, inherited rows
    always_comb begin
        logic [N-1:0] acc;
        logic [N-1:0] row;
        acc = '0;
        for (int k = 0; k < W; k++) begin
            row = mat_hit[k];
            for (int m = 0; m < W; m++) begin
                if (bat_hit[k][m]) row = row | grant_oh[m*N +: N];
            end
            row = row | acc;
            new_row[k] = in_valid[k] ? row : '0;
            acc = acc | new_row[k];
        end
    end

    // map each entry to the slot that claims it this cycle
    always_comb begin
        we = '0;
        for (int i = 0; i < N; i++) ws[i] = '0;
        for (int k = 0; k < W; k++) begin
            for (int i = 0; i < N; i++) begin
                if (accept && grant_oh[k*N + i]) begin
                    we[i] = 1'b1;
                    ws[i] = SW'(k);
                end
            end
        end
    end

    // entry state: allocate, retire, or clear completed columns
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
            dst_q  <= '0;
            sa_q   <= '0;
            sb_q   <= '0;
            for (int i = 0; i < N; i++) dep_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (we[i]) begin
                    busy_q[i]          <= 1'b1;
                    dst_q[i*RW +: RW]  <= in_dst[ws[i]*RW +: RW];
                    sa_q[i*RW +: RW]   <= in_src_a[ws[i]*RW +: RW];
                    sb_q[i*RW +: RW]   <= in_src_b[ws[i]*RW +: RW];
                    dep_q[i]           <= new_row[ws[i]];
                end else if (done_pulse[i]) begin
                    busy_q[i] <= 1'b0;
                    dep_q[i]  <= '0;
                end else begin
                    dep_q[i] <= dep_q[i] & ~done_pulse;
                end
            end
        end
    end

    // outputs: occupancy and readiness per entry
    always_comb begin
        for (int i = 0; i < N; i++) entry_ready[i] = busy_q[i] && (dep_q[i] == '0);
    end
    assign entry_busy = busy_q;

    // column summary used by the checks below
    always_comb begin
        col_any = '0;
        for (int i = 0; i < N; i++) col_any = col_any | dep_q[i];
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        p_diag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !dep_q[i][i]);
        p_free_row_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !busy_q[i] |-> (dep_q[i] == '0));
        p_done_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (done_pulse[i] && busy_q[i]) |=> !busy_q[i]);
        p_col_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (done_pulse[i] && busy_q[i]) |=> !col_any[i]);
    end

    p_alloc_free_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ((we & busy_q) == '0));
    p_alloc_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ($countones(we) == $countones(in_valid)));
    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|in_valid) && !accept) |=> (busy_q == ($past(busy_q) & ~$past(done_pulse))));
endmodule

// File: tb/issue_dep_matrix_tb_top.sv
`timescale 1ns/1ps
module issue_dep_matrix_tb_top;
    localparam real CLK_HALF = 2.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  in_valid = '0;
    logic [19:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic [7:0]  done_pulse = '0;
    logic        batch_accept;
    logic [11:0] slot_entry;
    logic [7:0]  entry_busy, entry_ready;

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    issue_dep_matrix dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .done_pulse(done_pulse),
        .batch_accept(batch_accept), .slot_entry(slot_entry),
        .entry_busy(entry_busy), .entry_ready(entry_ready)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [3:0]  vld;
        logic [19:0] dst;
        logic [19:0] sa;
        logic [19:0] sb;
        logic [7:0]  done;
        logic        acc;
        logic [11:0] slots;
        logic [7:0]  busy;
        logic [7:0]  rdy;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // R2: first entry, no hazards
        '{4'd2, 4'b0001, {15'd0,5'd5}, {15'd0,5'd1}, {15'd0,5'd2}, 8'h00, 1'b1, 12'h000, 8'h01, 8'h01},
        // R4: reads r5 written by e0
        '{4'd4, 4'b0001, {15'd0,5'd6}, {15'd0,5'd5}, 20'd0, 8'h00, 1'b1, 12'h001, 8'h03, 8'h01},
        // R5: writes r1 read by e0
        '{4'd5, 4'b0001, {15'd0,5'd1}, {15'd0,5'd7}, 20'd0, 8'h00, 1'b1, 12'h002, 8'h07, 8'h01},
        // R6: writes r6 like e1
        '{4'd6, 4'b0001, {15'd0,5'd6}, 20'd0, 20'd0, 8'h00, 1'b1, 12'h003, 8'h0F, 8'h01},
        // R9: complete e0, e1 and e2 become ready
        '{4'd9, 4'b0000, 20'd0, 20'd0, 20'd0, 8'h01, 1'b0, 12'h000, 8'h0E, 8'h06},
        // R7: all-r0 instruction waits on nothing
        '{4'd7, 4'b0001, 20'd0, 20'd0, 20'd0, 8'h00, 1'b1, 12'h000, 8'h0F, 8'h07},
        // R8: four-wide batch, later slots inherit slot 0 waits
        '{4'd8, 4'b1111, {5'd13,5'd12,5'd11,5'd10}, {5'd22,5'd10,5'd20,5'd6}, {5'd0,5'd0,5'd21,5'd0},
          8'h00, 1'b1, {3'd7,3'd6,3'd5,3'd4}, 8'hFF, 8'h07},
        // R3: full pool stalls
        '{4'd3, 4'b0001, {15'd0,5'd14}, 20'd0, 20'd0, 8'h00, 1'b0, 12'h000, 8'hFF, 8'h07},
        // R9: completion does not free in the same cycle
        '{4'd9, 4'b0001, {15'd0,5'd14}, 20'd0, 20'd0, 8'h0A, 1'b0, 12'h000, 8'hF5, 8'h35},
        // R3: three slots but two free entries
        '{4'd3, 4'b0111, {5'd0,5'd4,5'd3,5'd2}, 20'd0, 20'd0, 8'h00, 1'b0, 12'h000, 8'hF5, 8'h35},
        // R2/R9: sparse slots, retiring e4 is not a producer
        '{4'd2, 4'b0110, {5'd0,5'd16,5'd15,5'd0}, {5'd0,5'd15,5'd0,5'd0}, {5'd0,5'd10,5'd0,5'd0},
          8'h10, 1'b1, {3'd0,3'd3,3'd1,3'd0}, 8'hEF, 8'hE7},
        // R9: completion of a free entry is ignored
        '{4'd9, 4'b0000, 20'd0, 20'd0, 20'd0, 8'h10, 1'b0, 12'h000, 8'hEF, 8'hE7},
        // R10: e3 becomes ready when e1 completes
        '{4'd10, 4'b0000, 20'd0, 20'd0, 20'd0, 8'h02, 1'b0, 12'h000, 8'hED, 8'hED}
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] v, input logic [19:0] d, input logic [19:0] a,
                         input logic [19:0] b, input logic [7:0] dn);
        in_valid = v; in_dst = d; in_src_a = a; in_src_b = b; done_pulse = dn;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        drive('0, '0, '0, '0, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        #(CLK_HALF * 2 * 100000);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        check("R1", "busy", 32'(entry_busy), 32'h0);
        check("R1", "ready", 32'(entry_ready), 32'h0);
        check("R1", "accept", 32'(batch_accept), 32'h0);
        check("R1", "slots", 32'(slot_entry), 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i].vld, VECS[i].dst, VECS[i].sa, VECS[i].sb, VECS[i].done);
            #1;
            check($sformatf("R%0d", VECS[i].req), $sformatf("v%0d accept", i),
                  32'(batch_accept), 32'(VECS[i].acc));
            if (VECS[i].acc)
                check($sformatf("R%0d", VECS[i].req), $sformatf("v%0d slots", i),
                      32'(slot_entry), 32'(VECS[i].slots));
            @(posedge clk);
            #1;
            check($sformatf("R%0d", VECS[i].req), $sformatf("v%0d busy", i),
                  32'(entry_busy), 32'(VECS[i].busy));
            check($sformatf("R%0d", VECS[i].req), $sformatf("v%0d ready", i),
                  32'(entry_ready), 32'(VECS[i].rdy));
        end

        // R1: reset in mid-run clears a populated matrix
        do_reset();
        check("R1", "busy after reset", 32'(entry_busy), 32'h0);
        check("R1", "ready after reset", 32'(entry_ready), 32'h0);

        // R2 R10: four independent slots fill entries 0..3, all ready
        @(negedge clk);
        drive(4'b1111, '0, '0, '0, '0);
        #1;
        check("R2", "full batch accept", 32'(batch_accept), 32'h1);
        check("R2", "full batch slots", 32'(slot_entry), 32'h688);
        @(posedge clk);
        #1;
        check("R10", "independent busy", 32'(entry_busy), 32'h0F);
        check("R10", "independent ready", 32'(entry_ready), 32'h0F);

        // R3: empty batch is never accepted even with free entries
        @(negedge clk);
        drive('0, '0, '0, '0, '0);
        #1;
        check("R3", "empty batch", 32'(batch_accept), 32'h0);
        @(posedge clk);
        #1;
        check("R3", "empty batch busy", 32'(entry_busy), 32'h0F);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule